// File: doc/BRIEF.md
# Condition Code and Branch Enable Unit

This unit keeps the three sign flags of a 16-bit processor (negative, zero, positive) and turns them into a branch decision for the control sequencer. Whenever the controller writes a result into the register file, it also pulses `cc_load`. The unit then classifies the word on the internal data bus and records which of the three flags applies. Only one flag is ever set.

In the decode step of a conditional branch, the controller pulses `ben_load`. The unit compares the three mask bits in the instruction word against the stored flags and checks that the opcode field is the branch opcode. It then latches the result in `ben`. The latched value stays put until the next `ben_load`, so the sequencer's following state can choose between the taken path and the fall-through path.

The flags are presented on `status_cc`, ready to be placed in the lowest bits of the processor status word. All pins are plain control and status signals. The unit has no streaming interface and no back-pressure.

Top module: `cc_branch_unit`

## Requirements
- R1: While `rst_n` is low, and at the first edge after it goes high, `status_cc` is 3'b010 (zero flag only) and `ben` is 0.
- R2: On a rising edge with `cc_load` high, the negative flag `status_cc[2]` takes the value of `bus_val[15]`.
- R3: On a rising edge with `cc_load` high and `bus_val` equal to zero, `status_cc` becomes 3'b010.
- R4: On a rising edge with `cc_load` high, `bus_val` nonzero and `bus_val[15]` clear, `status_cc` becomes 3'b001.
- R5: On an edge with `cc_load` low, `status_cc` keeps its value, whatever `bus_val` carries.
- R6: `status_cc` is ordered with negative in bit 2, zero in bit 1 and positive in bit 0.
- R7: On an edge with `ben_load` high, `ben` becomes 1 exactly when `ir_word[15:12]` is 4'b0000 and at least one of these holds: `ir_word[11]` and the negative flag are both set, `ir_word[10]` and the zero flag are both set, or `ir_word[9]` and the positive flag are both set. Otherwise `ben` becomes 0.
- R8: With opcode 4'b0000, a mask `ir_word[11:9]` of 3'b000 always latches `ben` = 0, and a mask of 3'b111 always latches `ben` = 1.
- R9: On an edge with `ben_load` low, `ben` keeps its value.
- R10: Exactly one bit of `status_cc` is set at all times after reset.
- R11: When `cc_load` and `ben_load` are high on the same edge, `ben` is computed from the flags held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_val | input | 16 | Word on the internal data bus |
| ir_word | input | 16 | Current instruction word |
| cc_load | input | 1 | Load the flags from `bus_val` |
| ben_load | input | 1 | Evaluate the branch condition and latch it |
| status_cc | output | 3 | Flags {negative, zero, positive} |
| ben | output | 1 | Latched branch enable |

## Verification
The hardest situation to reach is the edge where both strobes are high at once. On that edge, the branch decision must use the flags from before the edge, while the flags themselves are replaced.

The stimulus table reaches this case twice. Each time, the flags are first set to a known value. Then one vector drives a new bus word together with a branch mask. That mask matches only the old flags, or only the new ones, so the two possible orders of update give different `ben` values.

The opcode gate is also exercised. A mask that would match is paired with a nonzero opcode, and the bench expects `ben` to stay low.

// File: rtl/cc_branch_pkg.sv
package cc_branch_pkg;
  // Flag vector, ordered so that it drops into status bits [2:0].
  typedef struct packed {
    logic neg;
    logic zero;
    logic pos;
  } cc_flags_t;

  localparam cc_flags_t CC_RESET = '{neg: 1'b0, zero: 1'b1, pos: 1'b0};
endpackage

// File: rtl/cc_classify.sv
module cc_classify
  import cc_branch_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] word_i,
  output cc_flags_t         flags_o
);
  localparam int SIGN_BIT = DATA_W - 1;

  always_comb begin
    flags_o.neg  = word_i[SIGN_BIT];
    flags_o.zero = ~|word_i;
    flags_o.pos  = ~word_i[SIGN_BIT] & (|word_i);
  end
endmodule

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
  import cc_branch_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_i,
  input  cc_flags_t next_i,
  output cc_flags_t flags_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      flags_o <= CC_RESET;
    else if (load_i) flags_o <= next_i;
  end
endmodule

// File: rtl/br_enable_eval.sv
module br_enable_eval
  import cc_branch_pkg::*;
#(
  parameter int          DATA_W    = 16,
  parameter int          OPC_W     = 4,
  parameter int          MASK_W    = 3,
  parameter logic [3:0]  BR_OPCODE = 4'b0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] ir_i,
  input  cc_flags_t         flags_i,
  output logic              ben_o
);
  localparam int OPC_LO  = DATA_W - OPC_W;
  localparam int MASK_LO = OPC_LO - MASK_W;

  logic [MASK_W-1:0] mask;
  logic [MASK_W-1:0] flag_vec;
  logic [MASK_W-1:0] hit;
  logic              is_branch;

  assign mask      = ir_i[OPC_LO-1:MASK_LO];
  assign flag_vec  = flags_i;
  assign is_branch = (ir_i[DATA_W-1:OPC_LO] == BR_OPCODE[OPC_W-1:0]);

  for (genvar g = 0; g < MASK_W; g++) begin : g_match
    assign hit[g] = mask[g] & flag_vec[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ben_o <= 1'b0;
    else if (load_i) ben_o <= is_branch & (|hit);
  end
endmodule

// File: rtl/cc_branch_unit.sv
module cc_branch_unit
  import cc_branch_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OPC_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_val,
  input  logic [DATA_W-1:0] ir_word,
  input  logic              cc_load,
  input  logic              ben_load,
  output logic [2:0]        status_cc,
  output logic              ben
);
  cc_flags_t next_flags;
  cc_flags_t cur_flags;

  cc_classify #(.DATA_W(DATA_W)) u_classify (
    .word_i  (bus_val),
    .flags_o (next_flags)
  );

  cc_flag_reg u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (cc_load),
    .next_i  (next_flags),
    .flags_o (cur_flags)
  );

  br_enable_eval #(.DATA_W(DATA_W), .OPC_W(OPC_W)) u_ben (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (ben_load),
    .ir_i    (ir_word),
    .flags_i (cur_flags),
    .ben_o   (ben)
  );

  assign status_cc = cur_flags;
endmodule

// File: rtl/cc_branch_unit_chk.sv
module cc_branch_unit_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] bus_val,
  input logic [DATA_W-1:0] ir_word,
  input logic              cc_load,
  input logic              ben_load,
  input logic [2:0]        status_cc,
  input logic              ben
);
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (status_cc == 3'b010 && !ben));

  a_r10_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(status_cc) == 1);

  a_r2_neg_from_sign: assert property (@(posedge clk) disable iff (!rst_n)
    cc_load |=> status_cc[2] == $past(bus_val[DATA_W-1]));

  a_r3_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_load && bus_val == '0) |=> status_cc == 3'b010);

  a_r5_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !cc_load |=> $stable(status_cc));

  a_r9_hold_ben: assert property (@(posedge clk) disable iff (!rst_n)
    !ben_load |=> $stable(ben));

  a_r7_opcode_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (ben_load && ir_word[DATA_W-1:DATA_W-4] != 4'b0000) |=> !ben);

  a_r8_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (ben_load && ir_word[DATA_W-5:DATA_W-7] == 3'b000) |=> !ben);
endmodule

bind cc_branch_unit cc_branch_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_val   (bus_val),
  .ir_word   (ir_word),
  .cc_load   (cc_load),
  .ben_load  (ben_load),
  .status_cc (status_cc),
  .ben       (ben)
);

// File: tb/cc_branch_unit_tb.sv
module cc_branch_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_val = '0;
  logic [15:0] ir_word = '0;
  logic        cc_load = 1'b0;
  logic        ben_load = 1'b0;
  logic [2:0]  status_cc;
  logic        ben;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cc_branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_val(bus_val), .ir_word(ir_word),
    .cc_load(cc_load), .ben_load(ben_load), .status_cc(status_cc), .ben(ben)
  );

  // {bus, ir, cc_load, ben_load, expected flags {N,Z,P}, expected ben}
  localparam int NV = 15;
  localparam logic [37:0] VEC [NV] = '{
    {16'h8000, 16'h0000, 1'b1, 1'b0, 3'b100, 1'b0}, // R2 R6 sign bit -> N
    {16'h0000, 16'h0800, 1'b0, 1'b1, 3'b100, 1'b1}, // R5 R7 n-mask hit
    {16'h0000, 16'h0800, 1'b1, 1'b1, 3'b010, 1'b1}, // R11 old N used
    {16'h1234, 16'h0800, 1'b0, 1'b1, 3'b010, 1'b0}, // R7 n-mask miss
    {16'h1234, 16'h0400, 1'b0, 1'b1, 3'b010, 1'b1}, // R7 z-mask hit
    {16'h7FFF, 16'h0400, 1'b1, 1'b0, 3'b001, 1'b1}, // R4 R9 ben held
    {16'h7FFF, 16'h0200, 1'b0, 1'b1, 3'b001, 1'b1}, // R7 p-mask hit
    {16'h7FFF, 16'h1200, 1'b0, 1'b1, 3'b001, 1'b0}, // R7 opcode not branch
    {16'h7FFF, 16'h0000, 1'b0, 1'b1, 3'b001, 1'b0}, // R8 empty mask
    {16'h7FFF, 16'h0E00, 1'b0, 1'b1, 3'b001, 1'b1}, // R8 full mask
    {16'h0001, 16'h0FFF, 1'b1, 1'b1, 3'b001, 1'b1}, // R4 smallest positive
    {16'hFFFF, 16'h0C00, 1'b1, 1'b1, 3'b100, 1'b0}, // R11 old P used, nz miss
    {16'h0000, 16'hF800, 1'b0, 1'b1, 3'b100, 1'b0}, // R5 R7 bus ignored, opcode gate
    {16'h0000, 16'h0000, 1'b1, 1'b0, 3'b010, 1'b0}, // R3 zero word
    {16'h0000, 16'h0E00, 1'b0, 1'b1, 3'b010, 1'b1}  // R8 full mask on Z
  };
  localparam int VREQ [NV] = '{2, 7, 11, 7, 7, 4, 7, 7, 8, 8, 4, 11, 5, 3, 8};

  task automatic check(input string req, input logic [2:0] exp_cc, input logic exp_ben);
    checks++;
    if (status_cc !== exp_cc || ben !== exp_ben) begin
      fails++;
      $display("FAIL %s: status_cc=%b ben=%b expected status_cc=%b ben=%b",
               req, status_cc, ben, exp_cc, exp_ben);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    // R1 reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", 3'b010, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 3'b010, 1'b0);

    for (int i = 0; i < NV; i++) begin
      {bus_val, ir_word, cc_load, ben_load} = VEC[i][37:4];
      @(negedge clk);
      check($sformatf("R%0d", VREQ[i]), VEC[i][3:1], VEC[i][0]);
      checks++;
      if ($countones(status_cc) != 1) begin // R10
        fails++;
        $display("FAIL R10: status_cc=%b expected one bit set", status_cc);
      end
    end

    // R9 / R5: strobes low, inputs changing, outputs hold
    cc_load = 1'b0; ben_load = 1'b0;
    bus_val = 16'h8001; ir_word = 16'h0000;
    repeat (3) @(negedge clk);
    check("R9", 3'b010, 1'b1);

    // R1 reset in mid-run clears a set ben and restores Z
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", 3'b010, 1'b0);
    rst_n = 1'b1;
    cc_load = 1'b1; bus_val = 16'h8001;
    @(negedge clk);
    cc_load = 1'b0;
    check("R2", 3'b100, 1'b0);

    done = 1'b1;
    finish_run();
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end
endmodule